// File: doc/BRIEF.md
# Multi-core masked interrupt router

The block collects 72 hardware interrupt lines, one external interrupt line and eight software-raised trigger bits, and fans them out to four processor cores. Each core has two outputs, a normal interrupt line and a fast interrupt line. Each of these eight outputs has its own enable mask. Software never writes a mask directly. It sets mask bits through a set register and removes them through a separate clear register, so no read-modify-write is needed.

Sources are handled as three 32-bit words. Word 0 carries lines 31:0 and word 1 carries lines 63:32. Word 2 carries lines 71:64 in bits 7:0, the software triggers in bits 15:8 and the external line in bit 31. For every core and output kind there is a pending view equal to the raw word ANDed with the mask. Pending word 2 also holds two summary bits that tell software which of the lower words to read. The raw, unmasked words are readable at a single shared address range.

Access is through a simple synchronous register port: byte address, write enable, write data, and read data that is registered one cycle after the address is presented.

Top module: `irq_router`

## Requirements
- R1: After reset every mask word and every software trigger bit is zero, all eight outputs are low, and every mask register reads zero.
- R2: A write to a set-enable register (group base + 0x10/0x14/0x18 for words 0/1/2) ORs the 1 bits of the write data into that mask word and leaves the 0 bits unchanged. Only bits 31 and 15:0 of mask word 2 can be set. Reading the set-enable or the clear-enable address of a word returns the current mask.
- R3: A write to a clear-enable register (group base + 0x20/0x24/0x28) clears each mask bit written as 1. Bits written as 0 are unchanged.
- R4: Pending word n (group base + 0x00/0x04/0x08) reads as raw word n AND mask word n. In pending word 2, bit 25 is the OR of pending word 1 and bit 24 is the OR of pending word 0.
- R5: The interrupt or fast-interrupt output of a core is high exactly when any pending bit of that group is set. Sources are level inputs registered on each clock, so an output follows a source change after one clock edge and drops when the source drops.
- R6: Raw words read at 0x230/0x234/0x238. They are source lines 31:0, source lines 63:32, and {external line, 15 zeros, software triggers, lines 71:64}.
- R7: A write to 0x3F0 sets the software trigger bits that are 1 in write data bits 7:0, and a write to 0x3F4 clears them. Nothing else clears a trigger bit. The trigger bits feed the masks and outputs like hardware sources.
- R8: Normal-interrupt groups start at 0x200 and fast-interrupt groups start at 0x300, with core c at +0x40*c. The masks of different cores, and of the two kinds on one core, are independent.
- R9: Writes to pending or raw-status addresses have no effect. Reserved bits, the trigger set/clear addresses, misaligned addresses and unmapped addresses read as zero.
- R10: rdata_o changes only on a clock edge. It shows the data of the address presented in the cycle before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 72 | Hardware interrupt source lines, level sensitive |
| ext_irq_i | input | 1 | External interrupt line, raw word 2 bit 31 |
| addr_i | input | 12 | Register byte address |
| we_i | input | 1 | Write enable |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 4 | Per-core normal interrupt outputs |
| fiq_o | output | 4 | Per-core fast interrupt outputs |

## Verification
The hardest state to reach is a trigger bit that has survived every write that is not the trigger-clear write. That bit comes only from software, so the stimulus first raises it through the set address. It then sends the writes that could plausibly disturb it: an all-zero set write, and an all-ones write to the raw-status word that displays the bit. It then confirms the bit is still routed to a core output before the clear write removes it. The independence of the eight masks is reached by filling one group entirely, then reading the pending views of the neighbouring groups and observing all outputs.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int unsigned ADDR_W  = 12;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned N_WORDS = 3;
  localparam int unsigned HW_SRC  = 72;
  localparam int unsigned SW_W    = 8;
  localparam int unsigned HI_SRC  = HW_SRC - 2 * WORD_W;
  localparam logic [WORD_W-1:0] W2_KEEP = 32'h8000_FFFF;

  typedef logic [N_WORDS-1:0][WORD_W-1:0] bank_t;

  typedef enum logic [2:0] {
    K_NONE, K_PEND, K_SET, K_CLR, K_STAT, K_SWSET, K_SWCLR
  } kind_e;

  typedef struct packed {
    kind_e      kind;
    logic       fiq;
    logic [1:0] core;
    logic [1:0] word;
  } dec_t;
endpackage

// File: rtl/irq_addr_dec.sv
module irq_addr_dec
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  output dec_t              dec_o
);
  logic in_win, core_ok;

  assign in_win  = (addr_i[11:9] == 3'b001) && (addr_i[1:0] == 2'b00) && (addr_i[3:2] != 2'd3);
  assign core_ok = ({30'd0, addr_i[7:6]} < NUM_CORES);

  always_comb begin
    dec_o      = '0;
    dec_o.kind = K_NONE;
    dec_o.fiq  = addr_i[8];
    dec_o.core = addr_i[7:6];
    dec_o.word = addr_i[3:2];
    if (in_win) begin
      unique case (addr_i[5:4])
        2'd0: if (core_ok) dec_o.kind = K_PEND;
        2'd1: if (core_ok) dec_o.kind = K_SET;
        2'd2: if (core_ok) dec_o.kind = K_CLR;
        default: begin
          if (!addr_i[8] && addr_i[7:6] == 2'd0) dec_o.kind = K_STAT;
          else if (addr_i[8] && addr_i[7:6] == 2'd3) begin
            if (addr_i[3:2] == 2'd0)      dec_o.kind = K_SWSET;
            else if (addr_i[3:2] == 2'd1) dec_o.kind = K_SWCLR;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank
  import irq_router_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_i,
  input  logic              clr_i,
  input  logic [1:0]        word_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  bank_t             raw_i,
  output bank_t             mask_o,
  output bank_t             pend_o,
  output logic              line_o
);
  bank_t mask_q, hit;

  for (genvar w = 0; w < N_WORDS; w++) begin : g_word
    localparam logic [WORD_W-1:0] KEEP = (w == N_WORDS - 1) ? W2_KEEP : '1;
    logic [WORD_W-1:0] set_bits, clr_bits;
    assign set_bits = (set_i && word_i == 2'(w)) ? (wdata_i & KEEP) : '0;
    assign clr_bits = (clr_i && word_i == 2'(w)) ? wdata_i : '0;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mask_q[w] <= '0;
      else         mask_q[w] <= (mask_q[w] | set_bits) & ~clr_bits;  // clear wins
    end

    assign hit[w] = raw_i[w] & mask_q[w];
  end

  assign mask_o    = mask_q;
  assign pend_o[0] = hit[0];
  assign pend_o[1] = hit[1];
  assign pend_o[2] = hit[2] | {6'd0, |hit[1], |hit[0], 24'd0};
  assign line_o    = |hit;
endmodule

// File: rtl/irq_sw_trig.sv
module irq_sw_trig
  import irq_router_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            set_i,
  input  logic            clr_i,
  input  logic [SW_W-1:0] bits_i,
  output logic [SW_W-1:0] trig_o
);
  logic [SW_W-1:0] trig_q, set_bits, clr_bits;

  assign set_bits = set_i ? bits_i : '0;
  assign clr_bits = clr_i ? bits_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trig_q <= '0;
    else         trig_q <= (trig_q | set_bits) & ~clr_bits;
  end

  assign trig_o = trig_q;
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [HW_SRC-1:0]    src_i,
  input  logic                 ext_irq_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 we_i,
  input  logic [WORD_W-1:0]    wdata_i,
  output logic [WORD_W-1:0]    rdata_o,
  output logic [NUM_CORES-1:0] irq_o,
  output logic [NUM_CORES-1:0] fiq_o
);
  localparam int unsigned N_KIND = 2;

  dec_t                                    dec;
  logic [HW_SRC-1:0]                       src_q;
  logic                                    ext_q;
  logic [SW_W-1:0]                         sw_q;
  bank_t                                   raw;
  bank_t [N_KIND-1:0][NUM_CORES-1:0]       mask_all, pend_all;
  logic  [N_KIND-1:0][NUM_CORES-1:0]       line;
  logic [WORD_W-1:0]                       rd_next, rdata_q;

  irq_addr_dec #(.NUM_CORES(NUM_CORES)) u_dec (.addr_i(addr_i), .dec_o(dec));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q <= '0;
      ext_q <= 1'b0;
    end else begin
      src_q <= src_i;
      ext_q <= ext_irq_i;
    end
  end

  irq_sw_trig u_sw (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (we_i && dec.kind == K_SWSET),
    .clr_i  (we_i && dec.kind == K_SWCLR),
    .bits_i (wdata_i[SW_W-1:0]),
    .trig_o (sw_q)
  );

  assign raw[0] = src_q[WORD_W-1:0];
  assign raw[1] = src_q[2*WORD_W-1:WORD_W];
  assign raw[2] = {ext_q, {(WORD_W-1-SW_W-HI_SRC){1'b0}}, sw_q, src_q[HW_SRC-1:2*WORD_W]};

  for (genvar k = 0; k < N_KIND; k++) begin : g_kind
    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
      logic sel;
      assign sel = we_i && (dec.fiq == k[0]) && (dec.core == 2'(c));
      irq_mask_bank u_bank (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .set_i   (sel && dec.kind == K_SET),
        .clr_i   (sel && dec.kind == K_CLR),
        .word_i  (dec.word),
        .wdata_i (wdata_i),
        .raw_i   (raw),
        .mask_o  (mask_all[k][c]),
        .pend_o  (pend_all[k][c]),
        .line_o  (line[k][c])
      );
    end
  end

  assign irq_o = line[0];
  assign fiq_o = line[1];

  always_comb begin
    rd_next = '0;
    unique case (dec.kind)
      K_PEND:        rd_next = pend_all[dec.fiq][dec.core][dec.word];
      K_SET, K_CLR:  rd_next = mask_all[dec.fiq][dec.core][dec.word];
      K_STAT:        rd_next = raw[dec.word];
      default:       rd_next = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= rd_next;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4
) (
  input logic                             clk_i,
  input logic                             rst_ni,
  input logic [ADDR_W-1:0]                addr_i,
  input logic                             we_i,
  input logic [WORD_W-1:0]                wdata_i,
  input logic [WORD_W-1:0]                rdata_o,
  input logic [NUM_CORES-1:0]             irq_o,
  input logic [NUM_CORES-1:0]             fiq_o,
  input bank_t [1:0][NUM_CORES-1:0]       mask_all,
  input logic [SW_W-1:0]                  sw_q
);
  AST_MASK_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(mask_all)); // R2

  AST_SW_CLEAR_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == 12'h3F4) |=> ((sw_q & $past(sw_q)) == $past(sw_q))); // R7

  AST_LOW_ADDR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i < 12'h200) |=> (rdata_o == '0)); // R9

  for (genvar k = 0; k < 2; k++) begin : g_k
    for (genvar c = 0; c < NUM_CORES; c++) begin : g_c
      if (k == 0) begin : g_irq
        AST_OUT_NEEDS_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
          irq_o[c] |-> (mask_all[0][c] != '0)); // R5
      end else begin : g_fiq
        AST_OUT_NEEDS_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
          fiq_o[c] |-> (mask_all[1][c] != '0)); // R5
      end
      for (genvar w = 0; w < N_WORDS; w++) begin : g_w
        localparam int unsigned BASE = 'h200 + k * 'h100 + c * 'h40 + w * 4;
        localparam logic [WORD_W-1:0] KEEP = (w == N_WORDS - 1) ? W2_KEEP : '1;
        AST_SET_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
          (we_i && addr_i == 12'(BASE + 'h10)) |=>
            ((mask_all[k][c][w] & $past(wdata_i) & KEEP) == ($past(wdata_i) & KEEP))); // R2
        AST_CLR_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
          (we_i && addr_i == 12'(BASE + 'h20)) |=>
            ((mask_all[k][c][w] & $past(wdata_i)) == '0)); // R3
      end
    end
  end
endmodule

bind irq_router irq_router_chk #(.NUM_CORES(NUM_CORES)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .addr_i   (addr_i),
  .we_i     (we_i),
  .wdata_i  (wdata_i),
  .rdata_o  (rdata_o),
  .irq_o    (irq_o),
  .fiq_o    (fiq_o),
  .mask_all (mask_all),
  .sw_q     (sw_q)
);

// File: tb/irq_router_bench.sv
module irq_router_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [71:0] src_i = '0;
  logic        ext_irq_i = 1'b0;
  logic [11:0] addr_i = '0;
  logic        we_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [3:0]  irq_o, fiq_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk_i = ~clk_i;

  irq_router u_irq_router (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_i(src_i), .ext_irq_i(ext_irq_i),
    .addr_i(addr_i), .we_i(we_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .irq_o(irq_o), .fiq_o(fiq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; we_i = 1'b0;
    @(negedge clk_i);
    d = rdata_o;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic drive_src(input logic [71:0] s, input logic e);
    @(negedge clk_i);
    src_i = s; ext_irq_i = e;
    @(negedge clk_i);
  endtask

  task automatic t_reset;
    chk("R1 irq_o", {28'd0, irq_o}, 32'd0);
    chk("R1 fiq_o", {28'd0, fiq_o}, 32'd0);
    for (int c = 0; c < 4; c++) begin
      rd_chk("R1 irq mask", 12'(12'h210 + c * 'h40), 32'd0);
      rd_chk("R1 fiq mask", 12'(12'h318 + c * 'h40), 32'd0);
    end
    rd_chk("R1 sw triggers", 12'h238, 32'd0);
  endtask

  task automatic t_set_clear;
    wr(12'h210, 32'hA5A5_0001);
    rd_chk("R2 set read", 12'h210, 32'hA5A5_0001);
    rd_chk("R2 clr-addr read", 12'h220, 32'hA5A5_0001);
    wr(12'h210, 32'h0000_0F00);
    rd_chk("R2 or-in", 12'h210, 32'hA5A5_0F01);
    wr(12'h220, 32'h0000_0001);
    rd_chk("R3 clear bit", 12'h210, 32'hA5A5_0F00);
    wr(12'h220, 32'h0);
    rd_chk("R3 zero clear", 12'h210, 32'hA5A5_0F00);
    wr(12'h218, 32'hFFFF_FFFF);
    rd_chk("R2 word2 keep", 12'h218, 32'h8000_FFFF);
    wr(12'h220, 32'hFFFF_FFFF);
    wr(12'h228, 32'hFFFF_FFFF);
    rd_chk("R3 all cleared", 12'h210, 32'd0);
    rd_chk("R3 word2 cleared", 12'h228, 32'd0);
  endtask

  task automatic t_pending;
    wr(12'h354, 32'h0000_0008);
    wr(12'h350, 32'h0000_0001);
    drive_src(72'd1 << 35, 1'b0);
    chk("R5 fiq core1", {28'd0, fiq_o}, 32'h2);
    chk("R8 irq quiet", {28'd0, irq_o}, 32'h0);
    rd_chk("R4 pend1", 12'h344, 32'h8);
    rd_chk("R4 summary hi", 12'h348, 32'h0200_0000);
    rd_chk("R4 pend0 empty", 12'h340, 32'h0);
    drive_src((72'd1 << 35) | 72'd3, 1'b0);
    rd_chk("R4 pend0 masked", 12'h340, 32'h1);
    rd_chk("R4 summary both", 12'h348, 32'h0300_0000);
    drive_src('0, 1'b0);
    chk("R5 level drop", {28'd0, fiq_o}, 32'h0);
    wr(12'h298, 32'h8000_0000);
    drive_src('0, 1'b1);
    chk("R5 ext irq core2", {28'd0, irq_o}, 32'h4);
    rd_chk("R4 ext pending", 12'h288, 32'h8000_0000);
    drive_src('0, 1'b0);
    chk("R5 ext drop", {28'd0, irq_o}, 32'h0);
    wr(12'h360, 32'hFFFF_FFFF);
    wr(12'h364, 32'hFFFF_FFFF);
    wr(12'h2A8, 32'hFFFF_FFFF);
  endtask

  task automatic t_status;
    drive_src({8'hC3, 32'h1234_5678, 32'h9ABC_DEF0}, 1'b1);
    rd_chk("R6 raw0", 12'h230, 32'h9ABC_DEF0);
    rd_chk("R6 raw1", 12'h234, 32'h1234_5678);
    rd_chk("R6 raw2", 12'h238, 32'h8000_00C3);
    chk("R5 unmasked quiet", {24'd0, irq_o, fiq_o}, 32'h0);
    drive_src('0, 1'b0);
  endtask

  task automatic t_sw;
    wr(12'h3F0, 32'h0000_0081);
    rd_chk("R7 set triggers", 12'h238, 32'h0000_8100);
    chk("R7 unmasked sw", {28'd0, irq_o}, 32'h0);
    wr(12'h2D8, 32'h0000_0100);
    chk("R7 sw routed", {28'd0, irq_o}, 32'h8);
    rd_chk("R7 sw pending", 12'h2C8, 32'h0000_0100);
    wr(12'h3F0, 32'h0);
    rd_chk("R7 zero set keeps", 12'h238, 32'h0000_8100);
    wr(12'h238, 32'hFFFF_FFFF);
    rd_chk("R9 status write ignored", 12'h238, 32'h0000_8100);
    chk("R7 still routed", {28'd0, irq_o}, 32'h8);
    rd_chk("R9 sw set reads zero", 12'h3F0, 32'h0);
    wr(12'h3F4, 32'h0000_0001);
    chk("R7 sw cleared", {28'd0, irq_o}, 32'h0);
    rd_chk("R7 remaining trigger", 12'h238, 32'h0000_8000);
    wr(12'h3F4, 32'h0000_00FF);
    rd_chk("R7 all cleared", 12'h238, 32'h0);
    wr(12'h2E8, 32'hFFFF_FFFF);
  endtask

  task automatic t_indep;
    wr(12'h210, 32'hFFFF_FFFF);
    drive_src(72'd1 << 5, 1'b0);
    chk("R8 only core0 irq", {24'd0, irq_o, fiq_o}, 32'h10);
    rd_chk("R8 core0 fiq mask", 12'h310, 32'h0);
    rd_chk("R8 core1 irq mask", 12'h250, 32'h0);
    rd_chk("R8 core0 fiq pend", 12'h300, 32'h0);
    rd_chk("R8 core0 irq pend", 12'h200, 32'h20);
    drive_src('0, 1'b0);
    wr(12'h220, 32'hFFFF_FFFF);
  endtask

  task automatic t_ignored;
    wr(12'h250, 32'h0000_00F0);
    drive_src(72'd1 << 4, 1'b0);
    wr(12'h240, 32'hFFFF_FFFF);
    wr(12'h230, 32'h0);
    rd_chk("R9 mask intact", 12'h250, 32'h0000_00F0);
    rd_chk("R9 pending intact", 12'h240, 32'h0000_0010);
    chk("R9 output intact", {28'd0, irq_o}, 32'h2);
    rd_chk("R9 below window", 12'h100, 32'h0);
    rd_chk("R9 hole 0x2F0", 12'h2F0, 32'h0);
    rd_chk("R9 word3", 12'h20C, 32'h0);
    rd_chk("R9 0x3F8", 12'h3F8, 32'h0);
    rd_chk("R9 misaligned", 12'h252, 32'h0);
    drive_src('0, 1'b0);
    wr(12'h260, 32'hFFFF_FFFF);
  endtask

  task automatic t_latency;
    drive_src(72'h0000_0000_0000_00AA, 1'b0);
    rd_chk("R10 first read", 12'h230, 32'h0000_00AA);
    @(negedge clk_i);
    addr_i = 12'h234;
    #1;
    chk("R10 holds until edge", rdata_o, 32'h0000_00AA);
    @(negedge clk_i);
    chk("R10 next data", rdata_o, 32'h0);
    drive_src('0, 1'b0);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_set_clear();
    t_pending();
    t_status();
    t_sw();
    t_indep();
    t_ignored();
    t_latency();
    done = 1'b1;
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end
endmodule